// File: doc/BRIEF.md
# Ripple Bit-Slice ALU with Signed Compare

This block is a W-bit arithmetic/logic unit (default 16 bits). It is built from one
identical single-bit slice repeated at every position, with the carry passed from slice to slice.
Each slice holds its own logic AND, logic OR and full adder. It also has an overflow detector
and a result selector. A two-bit operation code picks what each slice drives onto its result bit.
Two control lines condition the adder: one inverts the b operand and one sets the carry into bit 0.
With these lines the adder can add, subtract or produce a complement.

The fourth operation is a signed compare. The adder computes a - b. The sign of the top slice,
corrected by that slice's overflow flag, is routed back to the result bit of slice 0. Every
other slice drives 0. The result is therefore 1 exactly when a < b (signed), and the zero
flag then tells the caller whether the compare failed. The top slice's carry-out and overflow
flag are the only ones brought out. All outputs are captured in one register stage that has a
synchronous active-high reset.

Top module: `bslice_alu`

## Requirements
- R1: With op_i = 2'b00, res_o equals a_i AND b_eff. Here b_eff is b_i, with every bit inverted when b_inv_i = 1.
- R2: With op_i = 2'b01, res_o equals a_i OR b_eff.
- R3: With op_i = 2'b10, {cout_o, res_o} equals a_i + b_eff + carry_i as a W+1-bit unsigned sum. With b_inv_i = 1 and carry_i = 1 this is a_i - b_i.
- R4: With op_i = 2'b01, b_inv_i = 1 and a_i = 0, res_o is the bitwise complement of b_i.
- R5: For every operation, ovf_o is 1 exactly when a_i[W-1] equals b_eff[W-1] and the adder sum's top bit differs from a_i[W-1].
- R6: With op_i = 2'b11, b_inv_i = 1 and carry_i = 1, res_o[0] is 1 when a_i < b_i as signed two's-complement numbers and 0 otherwise. This holds when the subtraction overflows as well.
- R7: With op_i = 2'b11, res_o[W-1:1] is 0. For any b_inv_i and carry_i, res_o[0] equals the adder sum's top bit XOR the top-slice overflow.
- R8: cout_o is always the carry out of the top slice of a_i + b_eff + carry_i, whatever the operation.
- R9: zero_o is 1 exactly when every bit of res_o is 0.
- R10: Outputs show the result for the inputs present at the previous rising clock edge. While rst is high at an edge, res_o, cout_o and ovf_o become 0 and zero_o becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W | Operand a |
| b_i | input | W | Operand b |
| op_i | input | 2 | Operation: 0 AND, 1 OR, 2 add, 3 signed compare |
| b_inv_i | input | 1 | Invert b before use |
| carry_i | input | 1 | Carry into slice 0 |
| res_o | output | W | Registered result |
| cout_o | output | 1 | Registered carry out of the top slice |
| ovf_o | output | 1 | Registered two's-complement overflow of the top slice |
| zero_o | output | 1 | Registered all-zero flag of the result |

## Verification
The compare and the overflow detector fire in the same cycle when a - b overflows under op 3. In that case the raw sign bit gives the wrong answer, and only the overflow correction makes bit 0 right. The bench provokes this with directed pairs such as most-negative minus one and most-positive minus minus-one, and it mixes in random operands. Each compare is judged against a signed comparison computed in the bench. The bench checks at the same time that ovf_o is raised and that zero_o follows the one-bit result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND   = 2'b00,
        OP_OR    = 2'b01,
        OP_ARITH = 2'b10,
        OP_SLT   = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic res;
        logic sum;
        logic cout;
        logic ovf;
    } slice_out_t;

    // Two's-complement overflow from sign bits of the operands and the sum.
    function automatic logic ovf_detect(input logic a_s, input logic b_s, input logic s_s);
        return (a_s == b_s) && (s_s != a_s);
    endfunction

    function automatic logic full_carry(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x ^ y));
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       b_inv_i,
    input  logic       c_i,
    input  logic       less_i,
    input  alu_op_e    op_i,
    output slice_out_t out_o
);
    logic b_eff;
    logic s;

    always_comb begin
        b_eff      = b_i ^ b_inv_i;
        s          = a_i ^ b_eff ^ c_i;
        out_o.sum  = s;
        out_o.cout = full_carry(a_i, b_eff, c_i);
        out_o.ovf  = ovf_detect(a_i, b_eff, s);
        unique case (op_i)
            OP_AND:   out_o.res = a_i & b_eff;
            OP_OR:    out_o.res = a_i | b_eff;
            OP_ARITH: out_o.res = s;
            default:  out_o.res = less_i;
        endcase
    end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         [W-1:0] a_i,
    input  logic         [W-1:0] b_i,
    input  alu_op_e              op_i,
    input  logic                 b_inv_i,
    input  logic                 carry_i,
    output logic         [W-1:0] res_o,
    output logic                 cout_o,
    output logic                 ovf_o,
    output logic                 zero_o
);
    localparam int MSB = W - 1;

    logic set_bit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic       cin_w;
        logic       less_w;
        slice_out_t so;

        if (i == 0) begin : g_lsb
            assign cin_w  = carry_i;
            assign less_w = set_bit;
        end else begin : g_upper
            assign cin_w  = g_bit[i-1].so.cout;
            assign less_w = 1'b0;
        end

        alu_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .b_inv_i (b_inv_i),
            .c_i     (cin_w),
            .less_i  (less_w),
            .op_i    (op_i),
            .out_o   (so)
        );

        assign res_o[i] = so.res;
    end

    // Sign of a - b corrected by overflow, fed back to slice 0 (R6, R7).
    assign set_bit = g_bit[MSB].so.sum ^ g_bit[MSB].so.ovf;
    assign cout_o  = g_bit[MSB].so.cout;
    assign ovf_o   = g_bit[MSB].so.ovf;
    assign zero_o  = ~|res_o;
endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    input  logic         b_inv_i,
    input  logic         carry_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         ovf_o,
    output logic         zero_o
);
    localparam int MSB = W - 1;

    alu_op_e      op_e;
    logic [W-1:0] res_w;
    logic         cout_w;
    logic         ovf_w;
    logic         zero_w;

    assign op_e = alu_op_e'(op_i);

    alu_ripple #(.W(W)) u_ripple (
        .a_i     (a_i),
        .b_i     (b_i),
        .op_i    (op_e),
        .b_inv_i (b_inv_i),
        .carry_i (carry_i),
        .res_o   (res_w),
        .cout_o  (cout_w),
        .ovf_o   (ovf_w),
        .zero_o  (zero_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o  <= '0;
            cout_o <= 1'b0;
            ovf_o  <= 1'b0;
            zero_o <= 1'b1;
        end else begin
            res_o  <= res_w;
            cout_o <= cout_w;
            ovf_o  <= ovf_w;
            zero_o <= zero_w;
        end
    end

    // Assertions
    logic [W-1:0] beff_w;
    logic [W:0]   ref_sum;
    assign beff_w  = b_i ^ {W{b_inv_i}};
    assign ref_sum = {1'b0, a_i} + {1'b0, beff_w} + {{W{1'b0}}, carry_i};

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (res_o == '0 && !cout_o && !ovf_o && zero_o));

    a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (zero_o == (res_o == '0)));

    a_r1_and: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b00) |=> (res_o == $past(a_i & beff_w)));

    a_r2_or: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b01) |=> (res_o == $past(a_i | beff_w)));

    a_r3_add: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b10) |=> ({cout_o, res_o} == $past(ref_sum)));

    a_r8_carry: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cout_o == $past(ref_sum[W])));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (a_i[MSB] != beff_w[MSB]) |=> !ovf_o);

    a_r7_set_upper: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b11) |=> (res_o[MSB:1] == '0));

    a_r6_signed_lt: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b11 && b_inv_i && carry_i)
        |=> (res_o[0] == $past($signed(a_i) < $signed(b_i))));
endmodule

// File: tb/bslice_alu_bench.sv
`timescale 1ns/1ps
module bslice_alu_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_i, b_i;
    logic [1:0]   op_i;
    logic         b_inv_i, carry_i;
    logic [W-1:0] res_o;
    logic         cout_o, ovf_o, zero_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bslice_alu #(.W(W)) u_bslice_alu (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i),
        .b_inv_i(b_inv_i), .carry_i(carry_i),
        .res_o(res_o), .cout_o(cout_o), .ovf_o(ovf_o), .zero_o(zero_o)
    );

    function automatic logic [W-1:0] m_beff(input logic [W-1:0] b, input logic inv);
        return inv ? ~b : b;
    endfunction

    function automatic logic [W:0] m_sum(input logic [W-1:0] a, input logic [W-1:0] be, input logic c);
        return {1'b0, a} + {1'b0, be} + {{W{1'b0}}, c};
    endfunction

    function automatic logic m_ovf(input logic [W-1:0] a, input logic [W-1:0] be, input logic [W:0] s);
        return (a[W-1] == be[W-1]) && (s[W-1] != a[W-1]);
    endfunction

    function automatic logic [W-1:0] m_res(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] op, input logic inv, input logic c);
        logic [W-1:0] be;
        logic [W:0]   s;
        be = m_beff(b, inv);
        s  = m_sum(a, be, c);
        case (op)
            2'b00:   return a & be;
            2'b01:   return a | be;
            2'b10:   return s[W-1:0];
            default: return {{(W-1){1'b0}}, s[W-1] ^ m_ovf(a, be, s)};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] op, input logic inv, input logic c);
        logic [W-1:0] be, er;
        logic [W:0]   s;
        logic         eo;
        @(negedge clk);
        a_i = a; b_i = b; op_i = op; b_inv_i = inv; carry_i = c;
        be = m_beff(b, inv);
        s  = m_sum(a, be, c);
        er = m_res(a, b, op, inv, c);
        eo = m_ovf(a, be, s);
        @(negedge clk);
        case (op)
            2'b00:   chk(res_o == er, "R1 and", res_o, er);
            2'b01:   chk(res_o == er, "R2 or", res_o, er);
            2'b10:   chk({cout_o, res_o} == s, "R3 add", res_o, er);
            default: chk(res_o == er, "R7 set", res_o, er);
        endcase
        chk(cout_o == s[W], "R8 carry", {15'd0, cout_o}, {15'd0, s[W]});
        chk(ovf_o == eo, "R5 overflow", {15'd0, ovf_o}, {15'd0, eo});
        chk(zero_o == (er == '0), "R9 zero", {15'd0, zero_o}, {15'd0, (er == '0)});
        if (op == 2'b11 && inv && c)
            chk(res_o == {15'd0, ($signed(a) < $signed(b))}, "R6 signed lt",
                res_o, {15'd0, ($signed(a) < $signed(b))});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a_i = 16'hFFFF; b_i = 16'hFFFF; op_i = 2'b10; b_inv_i = 1'b0; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(res_o == '0 && !cout_o && !ovf_o && zero_o, "R10 reset", res_o, 16'h0);
        rst = 1'b0;
        // R10: one-cycle latency, output still reflects reset until next edge result lands
        apply(16'h1234, 16'h0F0F, 2'b00, 1'b0, 1'b0);
        apply(16'h1234, 16'h0F0F, 2'b00, 1'b1, 1'b0);
        apply(16'hA000, 16'h0005, 2'b01, 1'b0, 1'b0);
        // R4: complement of b via OR with a = 0
        apply(16'h0000, 16'h5A3C, 2'b01, 1'b1, 1'b0);
        chk(res_o == 16'hA5C3, "R4 complement", res_o, 16'hA5C3);
        // R3 subtract and carry / overflow corners
        apply(16'h0005, 16'h0003, 2'b10, 1'b1, 1'b1);
        apply(16'h7FFF, 16'h0001, 2'b10, 1'b0, 1'b0);
        apply(16'hFFFF, 16'h0001, 2'b10, 1'b0, 1'b0);
        apply(16'h8000, 16'h0001, 2'b10, 1'b1, 1'b1);
        // R6: compare corners including overflowing subtraction
        apply(16'h8000, 16'h0001, 2'b11, 1'b1, 1'b1);
        apply(16'h7FFF, 16'hFFFF, 2'b11, 1'b1, 1'b1);
        apply(16'h0003, 16'h0003, 2'b11, 1'b1, 1'b1);
        apply(16'hFFFE, 16'hFFFF, 2'b11, 1'b1, 1'b1);
        apply(16'h0001, 16'h8000, 2'b11, 1'b1, 1'b1);
        // R7: set with non-standard controls
        apply(16'h4000, 16'h4000, 2'b11, 1'b0, 1'b0);
        // R10: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(res_o == '0 && !cout_o && !ovf_o && zero_o, "R10 reset again", res_o, 16'h0);
        rst = 1'b0;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2000; k++) begin
            logic [W-1:0] ra, rb;
            logic [1:0]   rop;
            ra  = W'($urandom);
            rb  = W'($urandom);
            rop = 2'($urandom);
            if (k % 7 == 0) rb = ra;
            if (rop == 2'b11 && (k % 3 != 0))
                apply(ra, rb, rop, 1'b1, 1'b1);
            else
                apply(ra, rb, rop, 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule